// File: doc/BRIEF.md
# Self-Clocked Serial Register Port

This block is the device side of a serial port for a data converter in which the device is the clock master. The port generates its own serial clock by dividing the system clock. It still moves data only when the host opens a frame. A falling read-frame input starts a read, and a falling write-frame input starts a write. An address input chooses which register the frame touches.

The port holds one 24-bit control register, a small bank of 24-bit calibration registers, and an output register. Conversion results enter the output register on a single-cycle strobe. A ready flag (active low) tells the host that an unread result is waiting. An output read moves 16 or 24 bits, as the control register sets. The flag goes high again on the serial clock falling edge that follows the last bit. That same edge stops the serial clock and releases the data line.

Control bit 0 selects the long (24-bit) output word. Control bit 1 routes address-high reads to the calibration bank instead of the output register. Control bits 2 and up give the calibration bank index.

Top module: `selfclk_serial_port`

## Requirements
- R1: While reset is held and after its release, `ready_n` is 1, `sclk_out` is 0 and `sdo_en` is 0. The control register and the calibration registers read back as 0.
- R2: With `addr_sel` = 0 a frame addresses the control register. With `addr_sel` = 1 a read addresses the output register when control bit 1 is 0, and calibration register number ctrl[2] when control bit 1 is 1.
- R3: A `word_valid` strobe outside an output read loads `word_in` and drives `ready_n` to 0. Further strobes overwrite the word, and a later read returns the newest one.
- R4: A read frame aimed at the output register while `ready_n` is 1 moves nothing: `sdo_en` stays 0 and `sclk_out` stays low.
- R5: On the clock after `rd_frame_n` falls, `sdo_en` is 1 and `sdo` already carries the MSB. Later bits change only on falling `sclk_out` edges. One `sclk_out` period is DIV system clocks.
- R6: With control bit 0 = 0 an output read moves 16 bits, the upper 16 bits of the stored word. With control bit 0 = 1 it moves all 24 bits. Bits go MSB first.
- R7: The `sclk_out` falling edge after the last bit ends a read. At that edge `sdo_en` goes to 0 and `sclk_out` stays low. For an output read, `ready_n` goes to 1 at the same edge, and at no other time.
- R8: Control and calibration reads and writes always move exactly 24 bits. They run whatever `ready_n` is, and they leave it unchanged.
- R9: A falling `wr_frame_n` starts 24 `sclk_out` pulses. `sdi` is captured MSB first on the rising edges. The word lands in the control register when `addr_sel` = 0, or in calibration register ctrl[2] when `addr_sel` = 1.
- R10: A `word_valid` strobe during an output read is dropped. After that read `ready_n` is 1, and a new output read moves nothing.
- R11: `sclk_out` is low whenever no transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_valid | input | 1 | Strobe: new conversion word present |
| word_in | input | 24 | New conversion word |
| rd_frame_n | input | 1 | Read frame, active low |
| wr_frame_n | input | 1 | Write frame, active low |
| addr_sel | input | 1 | Register select, held for the whole frame |
| sdi | input | 1 | Serial write data |
| sclk_out | output | 1 | Generated serial clock, low when idle |
| sdo | output | 1 | Serial read data |
| sdo_en | output | 1 | Output enable for `sdo` |
| ready_n | output | 1 | Unread output word present, active low |

## Verification
The hardest case to reach is a result strobe that lands partway through an output read. The read must finish untouched, and the dropped word must leave no trace in the ready flag. The read task follows the generated clock at the ports and counts its rising edges. It fires the strobe right after a chosen edge, so the arrival falls inside the transfer. A second read attempt afterwards then shows, through the blocked-transfer behaviour, that the dropped word was never stored.

// File: rtl/sps_pkg.sv
package sps_pkg;
  typedef enum logic [1:0] {
    XF_IDLE  = 2'd0,
    XF_READ  = 2'd1,
    XF_WRITE = 2'd2
  } xfer_e;

  // control register field positions
  localparam int unsigned CTRL_LONG_BIT = 0;
  localparam int unsigned CTRL_CAL_BIT  = 1;
  localparam int unsigned CTRL_BANK_LSB = 2;
endpackage

// File: rtl/sps_clkgen.sv
module sps_clkgen #(
  parameter int unsigned DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic rise,
  output logic fall,
  output logic sclk
);
  localparam int unsigned HALF = DIV / 2;
  localparam int unsigned CW   = $clog2(DIV);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sclk_q, sclk_d;

  always_comb begin
    rise   = run && (cnt_q == CW'(HALF - 1));
    fall   = run && (cnt_q == CW'(DIV - 1));
    cnt_d  = '0;
    sclk_d = 1'b0;
    if (run) begin
      cnt_d = fall ? '0 : cnt_q + 1'b1;
      if (rise)      sclk_d = 1'b1;
      else if (fall) sclk_d = 1'b0;
      else           sclk_d = sclk_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk = sclk_q;
endmodule

// File: rtl/sps_engine.sv
module sps_engine
  import sps_pkg::*;
#(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned BCW    = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_start,
  input  logic              wr_start,
  input  logic [DATA_W-1:0] load_word,
  input  logic [BCW-1:0]    load_len,
  input  logic              sdi,
  input  logic              rise,
  input  logic              fall,
  output logic              busy,
  output logic              reading,
  output logic              sdo_raw,
  output logic              rd_end,
  output logic              wr_end,
  output logic [DATA_W-1:0] wr_word
);
  xfer_e             state_q, state_d;
  logic [DATA_W-1:0] shreg_q, shreg_d;
  logic [BCW-1:0]    idx_q, idx_d;
  logic [BCW-1:0]    last_q, last_d;

  always_comb begin
    state_d = state_q;
    shreg_d = shreg_q;
    idx_d   = idx_q;
    last_d  = last_q;
    rd_end  = 1'b0;
    wr_end  = 1'b0;
    unique case (state_q)
      XF_IDLE: begin
        if (rd_start) begin
          state_d = XF_READ;
          shreg_d = load_word;
          idx_d   = '0;
          last_d  = load_len - 1'b1;
        end else if (wr_start) begin
          state_d = XF_WRITE;
          shreg_d = '0;
          idx_d   = '0;
          last_d  = BCW'(DATA_W - 1);
        end
      end
      XF_READ: begin
        if (fall) begin
          if (idx_q == last_q) begin
            rd_end  = 1'b1;
            state_d = XF_IDLE;
          end else begin
            shreg_d = {shreg_q[DATA_W-2:0], 1'b0};
            idx_d   = idx_q + 1'b1;
          end
        end
      end
      XF_WRITE: begin
        if (rise) shreg_d = {shreg_q[DATA_W-2:0], sdi};
        if (fall) begin
          if (idx_q == last_q) begin
            wr_end  = 1'b1;
            state_d = XF_IDLE;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      default: state_d = XF_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XF_IDLE;
      shreg_q <= '0;
      idx_q   <= '0;
      last_q  <= '0;
    end else begin
      state_q <= state_d;
      shreg_q <= shreg_d;
      idx_q   <= idx_d;
      last_q  <= last_d;
    end
  end

  assign busy    = (state_q != XF_IDLE);
  assign reading = (state_q == XF_READ);
  assign sdo_raw = shreg_q[DATA_W-1];
  assign wr_word = shreg_q;
endmodule

// File: rtl/sps_regfile.sv
module sps_regfile #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned NCAL   = 2,
  parameter int unsigned BKW    = (NCAL > 1) ? $clog2(NCAL) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        word_valid,
  input  logic [DATA_W-1:0]           word_in,
  input  logic                        out_busy,
  input  logic                        out_done,
  input  logic                        wr_end,
  input  logic                        wr_to_ctrl,
  input  logic [BKW-1:0]              wr_bank,
  input  logic [DATA_W-1:0]           wr_word,
  output logic [DATA_W-1:0]           ctrl_q,
  output logic [DATA_W-1:0]           out_q,
  output logic [NCAL-1:0][DATA_W-1:0] cal_q,
  output logic                        ready_n
);
  logic [DATA_W-1:0] ctrl_d, out_d;
  logic              rdy_q, rdy_d;

  always_comb begin
    out_d  = out_q;
    rdy_d  = rdy_q;
    ctrl_d = ctrl_q;
    if (word_valid && !out_busy) begin
      out_d = word_in;
      rdy_d = 1'b0;
    end
    if (out_done) rdy_d = 1'b1;
    if (wr_end && wr_to_ctrl) ctrl_d = wr_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      out_q  <= '0;
      rdy_q  <= 1'b1;
    end else begin
      ctrl_q <= ctrl_d;
      out_q  <= out_d;
      rdy_q  <= rdy_d;
    end
  end

  for (genvar b = 0; b < NCAL; b++) begin : g_cal
    logic [DATA_W-1:0] bank_q, bank_d;
    logic              hit;
    always_comb begin
      hit    = wr_end && !wr_to_ctrl && (wr_bank == BKW'(b));
      bank_d = hit ? wr_word : bank_q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bank_q <= '0;
      else        bank_q <= bank_d;
    end
    assign cal_q[b] = bank_q;
  end

  assign ready_n = rdy_q;
endmodule

// File: rtl/selfclk_serial_port.sv
module selfclk_serial_port
  import sps_pkg::*;
#(
  parameter int unsigned DATA_W  = 24,
  parameter int unsigned SHORT_W = 16,
  parameter int unsigned DIV     = 8,
  parameter int unsigned NCAL    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_valid,
  input  logic [DATA_W-1:0] word_in,
  input  logic              rd_frame_n,
  input  logic              wr_frame_n,
  input  logic              addr_sel,
  input  logic              sdi,
  output logic              sclk_out,
  output logic              sdo,
  output logic              sdo_en,
  output logic              ready_n
);
  localparam int unsigned BCW = $clog2(DATA_W + 1);
  localparam int unsigned BKW = (NCAL > 1) ? $clog2(NCAL) : 1;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sn   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sn   <= rst_meta;
    end
  end

  logic                        busy, reading, sdo_raw, rd_end, wr_end;
  logic                        tick_rise, tick_fall;
  logic [DATA_W-1:0]           wr_word, ctrl_q, out_q;
  logic [NCAL-1:0][DATA_W-1:0] cal_q;

  // frame edge detection and transfer target latches
  logic           rfs_q, tfs_q, out_rd_q, wr_ctrl_q;
  logic           out_rd_d, wr_ctrl_d;
  logic [BKW-1:0] wr_bank_q, wr_bank_d;

  logic              long_word, cal_sel, src_out, rd_req, wr_req;
  logic              rd_start, wr_start;
  logic [BKW-1:0]    bank;
  logic [DATA_W-1:0] cal_rd, load_word;
  logic [BCW-1:0]    load_len;

  always_comb begin
    long_word = ctrl_q[CTRL_LONG_BIT];
    cal_sel   = ctrl_q[CTRL_CAL_BIT];
    bank      = ctrl_q[CTRL_BANK_LSB +: BKW];
    src_out   = addr_sel && !cal_sel;
    rd_req    = rfs_q && !rd_frame_n;
    wr_req    = tfs_q && !wr_frame_n;
    rd_start  = !busy && rd_req && (!src_out || !ready_n);
    wr_start  = !busy && !rd_req && wr_req;

    cal_rd = '0;
    for (int b = 0; b < NCAL; b++) begin
      if (bank == BKW'(b)) cal_rd = cal_q[b];
    end
    if (!addr_sel)    load_word = ctrl_q;
    else if (cal_sel) load_word = cal_rd;
    else              load_word = out_q;
    load_len = (src_out && !long_word) ? BCW'(SHORT_W) : BCW'(DATA_W);

    out_rd_d  = rd_start ? src_out   : out_rd_q;
    wr_ctrl_d = wr_start ? !addr_sel : wr_ctrl_q;
    wr_bank_d = wr_start ? bank      : wr_bank_q;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      rfs_q     <= 1'b1;
      tfs_q     <= 1'b1;
      out_rd_q  <= 1'b0;
      wr_ctrl_q <= 1'b0;
      wr_bank_q <= '0;
    end else begin
      rfs_q     <= rd_frame_n;
      tfs_q     <= wr_frame_n;
      out_rd_q  <= out_rd_d;
      wr_ctrl_q <= wr_ctrl_d;
      wr_bank_q <= wr_bank_d;
    end
  end

  sps_clkgen #(.DIV(DIV)) u_clkgen (
    .clk   (clk),
    .rst_n (rst_sn),
    .run   (busy),
    .rise  (tick_rise),
    .fall  (tick_fall),
    .sclk  (sclk_out)
  );

  sps_engine #(.DATA_W(DATA_W), .BCW(BCW)) u_engine (
    .clk       (clk),
    .rst_n     (rst_sn),
    .rd_start  (rd_start),
    .wr_start  (wr_start),
    .load_word (load_word),
    .load_len  (load_len),
    .sdi       (sdi),
    .rise      (tick_rise),
    .fall      (tick_fall),
    .busy      (busy),
    .reading   (reading),
    .sdo_raw   (sdo_raw),
    .rd_end    (rd_end),
    .wr_end    (wr_end),
    .wr_word   (wr_word)
  );

  sps_regfile #(.DATA_W(DATA_W), .NCAL(NCAL), .BKW(BKW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sn),
    .word_valid (word_valid),
    .word_in    (word_in),
    .out_busy   (reading && out_rd_q),
    .out_done   (rd_end && out_rd_q),
    .wr_end     (wr_end),
    .wr_to_ctrl (wr_ctrl_q),
    .wr_bank    (wr_bank_q),
    .wr_word    (wr_word),
    .ctrl_q     (ctrl_q),
    .out_q      (out_q),
    .cal_q      (cal_q),
    .ready_n    (ready_n)
  );

  assign sdo_en = reading;
  assign sdo    = reading ? sdo_raw : 1'b0;
endmodule

// File: rtl/sps_checker.sv
module sps_checker (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic sclk,
  input logic sdo,
  input logic sdo_en,
  input logic ready_n,
  input logic word_valid,
  input logic addr_sel,
  input logic cal_sel
);
  // R11: the serial clock only toggles inside a transfer
  a_r11_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> busy);

  // R7: the ready flag rises only at the edge that ends a transfer
  a_r7_ready_rise_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_n) |-> ($past(busy) && !busy));

  // R3: the ready flag falls only after a new-word strobe
  a_r3_ready_fall_on_word: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready_n) |-> $past(word_valid));

  // R4: an output read with no unread word never starts
  a_r4_blocked_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && addr_sel && !cal_sel && ready_n) |=> !sdo_en);

  // R5: read data holds still while the serial clock is high
  a_r5_sdo_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdo));

  // R7: data release leaves the serial clock low
  a_r7_release_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sdo_en) |-> !sclk);
endmodule

bind selfclk_serial_port sps_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_sn),
  .busy       (busy),
  .sclk       (sclk_out),
  .sdo        (sdo),
  .sdo_en     (sdo_en),
  .ready_n    (ready_n),
  .word_valid (word_valid),
  .addr_sel   (addr_sel),
  .cal_sel    (cal_sel)
);

// File: tb/selfclk_serial_port_test.sv
module selfclk_serial_port_test;
  localparam int DIVB = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        word_valid;
  logic [23:0] word_in;
  logic        rd_frame_n, wr_frame_n, addr_sel, sdi;
  logic        sclk_out, sdo, sdo_en, ready_n;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  selfclk_serial_port uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_valid (word_valid),
    .word_in    (word_in),
    .rd_frame_n (rd_frame_n),
    .wr_frame_n (wr_frame_n),
    .addr_sel   (addr_sel),
    .sdi        (sdi),
    .sclk_out   (sclk_out),
    .sdo        (sdo),
    .sdo_en     (sdo_en),
    .ready_n    (ready_n)
  );

  task automatic check(input bit ok, input string msg, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", msg, act, exp);
    end
  endtask

  task automatic strobe_word(input logic [23:0] v);
    @(negedge clk);
    word_valid = 1'b1;
    word_in    = v;
    @(negedge clk);
    word_valid = 1'b0;
    check(ready_n === 1'b0, "R3 ready low after strobe", ready_n, 0);
  endtask

  task automatic do_read(input logic a0, input int nb, input logic [23:0] expv,
                         input string req, input int strobe_at, input logic [23:0] strobe_v);
    logic [23:0] got;
    int   rises, cyc, t1, t2;
    logic prev;
    bit   fired;
    got = '0; rises = 0; cyc = 0; t1 = 0; t2 = 0; fired = 0;
    @(negedge clk);
    addr_sel   = a0;
    rd_frame_n = 1'b0;
    @(negedge clk);
    check(sdo_en === 1'b1, {req, " R5 enable at frame start"}, sdo_en, 1);
    check(sdo === expv[nb-1], {req, " R5 MSB at frame start"}, sdo, expv[nb-1]);
    prev = sclk_out;
    while (sdo_en && cyc < 30 * DIVB) begin
      @(negedge clk);
      cyc++;
      word_valid = 1'b0;
      if (sclk_out && !prev) begin
        rises++;
        got = {got[22:0], sdo};
        if (rises == 1) t1 = cyc;
        if (rises == 2) t2 = cyc;
        if (rises == strobe_at && !fired) begin
          word_valid = 1'b1;
          word_in    = strobe_v;
          fired      = 1;
        end
      end
      prev = sclk_out;
    end
    word_valid = 1'b0;
    check(rises == nb, {req, " bit count"}, rises, nb);
    check(got == expv, {req, " read data"}, got, expv);
    check(t2 - t1 == DIVB, {req, " R5 sclk period"}, t2 - t1, DIVB);
    check(sclk_out === 1'b0 && sdo_en === 1'b0, {req, " R7 clock and data off at end"},
          {sclk_out, sdo_en}, 0);
    rd_frame_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic blocked_read(input string req);
    int en_seen, clk_seen;
    en_seen = 0; clk_seen = 0;
    @(negedge clk);
    addr_sel   = 1'b1;
    rd_frame_n = 1'b0;
    repeat (6 * DIVB) begin
      @(negedge clk);
      if (sdo_en)   en_seen++;
      if (sclk_out) clk_seen++;
    end
    check(en_seen == 0, {req, " R4 no data enable"}, en_seen, 0);
    check(clk_seen == 0, {req, " R4 R11 clock stays low"}, clk_seen, 0);
    rd_frame_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_write(input logic a0, input logic [23:0] v, input string req);
    int   rises, cyc;
    logic prev, rdy0;
    bit   done;
    rises = 0; cyc = 0; done = 0;
    rdy0  = ready_n;
    @(negedge clk);
    sdi        = v[23];
    addr_sel   = a0;
    wr_frame_n = 1'b0;
    prev       = sclk_out;
    while (!done && cyc < 30 * DIVB) begin
      @(negedge clk);
      cyc++;
      if (sclk_out && !prev) rises++;
      if (!sclk_out && prev) begin
        if (rises < 24) sdi = v[23 - rises];
        else            done = 1;
      end
      prev = sclk_out;
    end
    repeat (3 * DIVB) begin
      @(negedge clk);
      if (sclk_out && !prev) rises++;
      prev = sclk_out;
    end
    check(rises == 24, {req, " R9 write pulse count"}, rises, 24);
    check(ready_n === rdy0, {req, " R8 write leaves ready"}, ready_n, rdy0);
    wr_frame_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; word_valid = 1'b0; word_in = '0;
    rd_frame_n = 1'b1; wr_frame_n = 1'b1; addr_sel = 1'b0; sdi = 1'b0;
    repeat (4) @(negedge clk);
    check(ready_n === 1'b1 && sclk_out === 1'b0 && sdo_en === 1'b0, "R1 reset outputs",
          {ready_n, sclk_out, sdo_en}, 3'b100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(ready_n === 1'b1 && sclk_out === 1'b0 && sdo_en === 1'b0, "R1 after release",
          {ready_n, sclk_out, sdo_en}, 3'b100);

    // R1 R2 R8: control register reads zero, 24 bits, with ready high
    do_read(1'b0, 24, 24'h000000, "R1 R2 R8 control read short", 0, '0);
    check(ready_n === 1'b1, "R8 control read leaves ready", ready_n, 1);

    // R4: nothing to read yet
    blocked_read("R4 empty");

    // R3 R6: overwrite, then 16-bit read of the newest word
    strobe_word(24'hA5C3F1);
    strobe_word(24'h5E1D27);
    do_read(1'b1, 16, 24'h005E1D, "R3 R6 short output read", 0, '0);
    check(ready_n === 1'b1, "R7 ready high after output read", ready_n, 1);

    // R9: select the long word, then read control back
    do_write(1'b0, 24'h000001, "R9 control write");
    do_read(1'b0, 24, 24'h000001, "R8 R9 control readback", 0, '0);

    // R6: 24-bit output read
    strobe_word(24'h3C96E2);
    do_read(1'b1, 24, 24'h3C96E2, "R6 long output read", 0, '0);

    // R10: word arrives mid-read and is lost
    strobe_word(24'h81F00D);
    do_read(1'b1, 24, 24'h81F00D, "R10 read with late word", 5, 24'h7777AA);
    check(ready_n === 1'b1, "R10 no ready after dropped word", ready_n, 1);
    blocked_read("R10 dropped word not stored");

    // R2 R9: calibration bank 0 and 1 writes, long mode
    do_write(1'b0, 24'h000003, "R9 control cal bank0");
    do_write(1'b1, 24'h12AB34, "R9 cal0 write");
    do_write(1'b0, 24'h000007, "R9 control cal bank1");
    do_write(1'b1, 24'hC0FFEE, "R9 cal1 write");
    do_read(1'b1, 24, 24'hC0FFEE, "R2 R8 cal1 read long", 0, '0);

    // R8: short mode, calibration reads still 24 bits and ignore ready
    do_write(1'b0, 24'h000002, "R9 control short cal bank0");
    strobe_word(24'h6B2F90);
    do_read(1'b1, 24, 24'h12AB34, "R2 R8 cal0 read short", 0, '0);
    check(ready_n === 1'b0, "R8 cal read leaves ready low", ready_n, 0);
    do_write(1'b0, 24'h000006, "R9 control short cal bank1");
    do_read(1'b1, 24, 24'hC0FFEE, "R2 R8 cal1 read short", 0, '0);
    do_read(1'b0, 24, 24'h000006, "R8 control read short", 0, '0);

    // R2 R6: back to output register, short word
    do_write(1'b0, 24'h000000, "R9 control output short");
    do_read(1'b1, 16, 24'h006B2F, "R2 R6 short output after cal", 0, '0);
    check(ready_n === 1'b1, "R7 ready high after final read", ready_n, 1);

    finish_run();
  end
endmodule